// File: doc/BRIEF.md
# Display Refresh Address Generator

This block produces the byte addresses that a display controller reads from display memory, one panel line at a time. A frame has three display areas, and they are always visited in the same order: the first, then the second, then the third. Each area has its own start address and its own number of lines. The memory path is 16 bits wide, so every fetch reads two bytes, and within a line the column advances by two bytes per fetch.

Each panel line is placed in its own memory row. Moving down one line adds exactly one row stride to the line's base address. Data for a line never continues into the unused tail of the previous row. The stride is fixed at 512 bytes when the memory is static RAM. For dynamic RAM the stride is a programmable power of two. The first two areas pan vertically only, because the column bits of their start address are ignored. The third area pans both vertically and horizontally.

All configuration is copied into shadow registers when a frame begins. Software can therefore move the window at any time simply by writing a new start address, and the picture never tears inside a frame. Timing comes from three strobes:
- `frame_start` begins a frame.
- `line_start` begins a line.
- `fetch_en` paces the fetches.

Top module: `refresh_addr_gen`

## Requirements
- R1: After reset `rd_vld` is low, and no fetch is issued until a `frame_start` followed by a `line_start`.
- R2: Areas are fetched in the fixed order first (`rd_area`=0), second (`rd_area`=1), third (`rd_area`=2). Each area is fetched for its own programmed line count, one line per accepted `line_start`.
- R3: A line issues `fetch_m1`+1 fetches, one per cycle in which `fetch_en` is high. Fetch k of a line has address line_base + 2·k. Each address appears on `rd_addr` with `rd_vld` one clock after the `fetch_en` cycle it belongs to.
- R4: With `mem_sdram`=0 the row stride is 512 bytes, so line l of an area starts at area_base + 512·l.
- R5: With `mem_sdram`=1 the row stride is 2^`sdram_row_bits` bytes, so line l starts at area_base + l·2^`sdram_row_bits`.
- R6: For the first and second areas, the column bits of the start address (the low log2(stride) bits) are treated as zero, which gives vertical panning only. The third area keeps its column bits, which gives horizontal panning.
- R7: Bit 0 of every start address is ignored, and every `rd_addr` is even.
- R8: Start addresses, line counts, `fetch_m1`, `mem_sdram` and `sdram_row_bits` are sampled only on `frame_start`. Changes made during a frame do not affect that frame and take effect from the next one.
- R9: An area whose line count is zero is skipped and issues no fetch.
- R10: Once the last line of the frame has been fetched, further `line_start` pulses issue nothing until the next `frame_start`. A `frame_start` drops any line in progress, restarts the frame with fresh configuration, and produces no fetch in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start of frame; loads the shadow configuration |
| line_start | input | 1 | Start of a panel line |
| fetch_en | input | 1 | One fetch per high cycle while a line is active |
| mem_sdram | input | 1 | 0: static RAM (512-byte rows); 1: dynamic RAM |
| sdram_row_bits | input | 4 | log2 of the row size in bytes when `mem_sdram`=1 |
| start_a | input | ADDR_W | Byte start address of the first area |
| start_b | input | ADDR_W | Byte start address of the second area |
| start_c | input | ADDR_W | Byte start address of the third area |
| lines_a | input | LINE_W | Line count of the first area |
| lines_b | input | LINE_W | Line count of the second area |
| lines_c | input | LINE_W | Line count of the third area |
| fetch_m1 | input | FETCH_W | Fetches per line minus one |
| rd_addr | output | ADDR_W | Byte address of the fetch |
| rd_vld | output | 1 | `rd_addr` holds a fetch this cycle |
| rd_area | output | 2 | Area of the current fetch (0, 1, 2) |

## Verification
The bench targets the following corner cases:
- **Column bits in the first two areas.** Start addresses with non-zero column bits are given to these areas. A design that honoured those bits would shift them sideways.
- **Odd start address.** The third area is given an odd start. A design that failed to clear bit 0 would issue odd addresses.
- **Stride under each memory type.** The stride is checked for both memory types. A design that packed lines back to back, or kept the 512-byte stride for dynamic RAM, would return wrong rows.
- **Empty middle area.** A design that skipped it badly would emit fetches tagged with that area.
- **Mid-frame configuration changes.** A design without shadowing would tear the frame.
- **Surplus line strobes after the frame ends.** A design that failed to stop would overrun the frame.

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen #(
  parameter int ADDR_W    = 24,
  parameter int LINE_W    = 10,
  parameter int FETCH_W   = 8,
  parameter int SRAM_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              fetch_en,
  input  logic              mem_sdram,
  input  logic [3:0]        sdram_row_bits,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] start_b,
  input  logic [ADDR_W-1:0] start_c,
  input  logic [LINE_W-1:0] lines_a,
  input  logic [LINE_W-1:0] lines_b,
  input  logic [LINE_W-1:0] lines_c,
  input  logic [FETCH_W-1:0] fetch_m1,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_vld,
  output logic [1:0]        rd_area
);

  localparam logic [1:0] DONE = 2'd3;

  logic [ADDR_W-1:0]  st_in [3];
  logic [LINE_W-1:0]  ln_in [3];
  logic [ADDR_W-1:0]  st_q  [3];
  logic [LINE_W-1:0]  ln_q  [3];
  logic [3:0]         rb_in, rb_q;
  logic [FETCH_W-1:0] fm1_q, cnt_q;
  logic [LINE_W-1:0]  line_q;
  logic [1:0]         area_q, first_a, next_a;
  logic [ADDR_W-1:0]  base_q, stride;
  logic               active_q, fire, line_end;

  assign st_in[0] = start_a;
  assign st_in[1] = start_b;
  assign st_in[2] = start_c;
  assign ln_in[0] = lines_a;
  assign ln_in[1] = lines_b;
  assign ln_in[2] = lines_c;

  assign rb_in  = mem_sdram ? sdram_row_bits : 4'(SRAM_BITS);
  assign stride = ADDR_W'(1) << rb_q;

  function automatic logic [1:0] pick(input logic [2:0] from,
                                      input logic [LINE_W-1:0] l0,
                                      input logic [LINE_W-1:0] l1,
                                      input logic [LINE_W-1:0] l2);
    if (from == 3'd0 && l0 != '0) return 2'd0;
    if (from <= 3'd1 && l1 != '0) return 2'd1;
    if (from <= 3'd2 && l2 != '0) return 2'd2;
    return DONE;
  endfunction

  function automatic logic [ADDR_W-1:0] area_base(input logic [ADDR_W-1:0] st,
                                                  input logic [3:0] rb,
                                                  input logic [1:0] a);
    logic [ADDR_W-1:0] b;
    b = (a == 2'd2) ? st : (st & ~((ADDR_W'(1) << rb) - ADDR_W'(1)));
    b[0] = 1'b0;
    return b;
  endfunction

  assign first_a  = pick(3'd0, lines_a, lines_b, lines_c);
  assign next_a   = pick({1'b0, area_q} + 3'd1, ln_q[0], ln_q[1], ln_q[2]);
  assign fire     = active_q && fetch_en && !frame_start;
  assign line_end = (cnt_q == fm1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        st_q[i] <= '0;
        ln_q[i] <= '0;
      end
      rb_q     <= 4'(SRAM_BITS);
      fm1_q    <= '0;
      cnt_q    <= '0;
      line_q   <= '0;
      area_q   <= DONE;
      base_q   <= '0;
      active_q <= 1'b0;
    end else if (frame_start) begin
      for (int i = 0; i < 3; i++) begin
        st_q[i] <= st_in[i];
        ln_q[i] <= ln_in[i];
      end
      rb_q     <= rb_in;
      fm1_q    <= fetch_m1;
      cnt_q    <= '0;
      line_q   <= '0;
      active_q <= 1'b0;
      area_q   <= first_a;
      base_q   <= (first_a == DONE) ? '0 : area_base(st_in[first_a], rb_in, first_a);
    end else begin
      if (!active_q && line_start && area_q != DONE) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
      if (fire) begin
        cnt_q <= cnt_q + 1'b1;
        if (line_end) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          if (line_q == ln_q[area_q] - 1'b1) begin
            area_q <= next_a;
            line_q <= '0;
            if (next_a != DONE) base_q <= area_base(st_q[next_a], rb_q, next_a);
          end else begin
            line_q <= line_q + 1'b1;
            base_q <= base_q + stride;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_addr <= '0;
      rd_area <= 2'd0;
    end else begin
      rd_vld  <= fire;
      rd_addr <= base_q + ADDR_W'({cnt_q, 1'b0});
      rd_area <= area_q;
    end
  end

  assert_even_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> !rd_addr[0]);

  assert_no_empty_area_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (rd_area != DONE && ln_q[rd_area] != '0));

  assert_silent_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (area_q == DONE && !frame_start) |=> !rd_vld);

  assert_abort_on_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !rd_vld);

  assert_area_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && $past(rd_vld) && !$past(frame_start, 2)) |-> rd_area >= $past(rd_area));

endmodule

// File: tb/refresh_addr_gen_tb.sv
module refresh_addr_gen_tb;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, line_start = 0, fetch_en = 0, mem_sdram = 0;
  logic [3:0]  sdram_row_bits = 4'd10;
  logic [23:0] start_a = 0, start_b = 0, start_c = 0;
  logic [9:0]  lines_a = 0, lines_b = 0, lines_c = 0;
  logic [7:0]  fetch_m1 = 0;
  logic [23:0] rd_addr;
  logic        rd_vld;
  logic [1:0]  rd_area;

  always #2.5 clk = ~clk;

  refresh_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .fetch_en(fetch_en), .mem_sdram(mem_sdram), .sdram_row_bits(sdram_row_bits),
    .start_a(start_a), .start_b(start_b), .start_c(start_c),
    .lines_a(lines_a), .lines_b(lines_b), .lines_c(lines_c),
    .fetch_m1(fetch_m1), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_area(rd_area));

  int checks = 0, fails = 0, ncap = 0;
  bit finished = 0;
  logic [23:0] cap_addr [0:1023];
  logic [1:0]  cap_area [0:1023];

  logic [23:0] e_st [3];
  int          e_ln [3];
  int          e_fm, e_rb;
  bit          e_sd;

  always @(negedge clk) if (rd_vld && ncap < 1024) begin
    cap_addr[ncap] = rd_addr;
    cap_area[ncap] = rd_area;
    ncap++;
  end

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    e_st[0] = start_a; e_st[1] = start_b; e_st[2] = start_c;
    e_ln[0] = lines_a; e_ln[1] = lines_b; e_ln[2] = lines_c;
    e_fm = fetch_m1; e_sd = mem_sdram; e_rb = sdram_row_bits;
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask

  task automatic drive_lines(input int slots);
    repeat (slots) begin
      @(negedge clk) line_start = 1;
      @(negedge clk) line_start = 0; fetch_en = 1;
      repeat (e_fm + 3) @(negedge clk);
      fetch_en = 0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic verify(input string tag, input int from);
    int stride, n;
    logic [23:0] base, mask, e;
    stride = e_sd ? (1 << e_rb) : 512;
    mask = 24'(stride - 1);
    n = from;
    for (int a = 0; a < 3; a++) begin
      base = (a == 2) ? e_st[a] : (e_st[a] & ~mask);
      base[0] = 1'b0;
      for (int l = 0; l < e_ln[a]; l++)
        for (int k = 0; k <= e_fm; k++) begin
          e = base + 24'(l * stride + 2 * k);
          if (n < ncap)
            check({tag, " addr/area"}, cap_addr[n] == e && cap_area[n] == 2'(a),
                  {cap_area[n], cap_addr[n]}, {2'(a), e});
          n++;
        end
    end
    check({tag, " fetch count"}, ncap == n, ncap - from, n - from);
  endtask

  task automatic full_frame(input string tag, input int extra);
    int from;
    snap();
    pulse_frame();
    from = ncap;
    drive_lines(e_ln[0] + e_ln[1] + e_ln[2] + extra);
    verify(tag, from);
  endtask

  task automatic t_reset();
    check("R1 reset rd_vld", rd_vld == 0, rd_vld, 0);
    @(negedge clk) line_start = 1;
    @(negedge clk) line_start = 0; fetch_en = 1;
    repeat (4) @(negedge clk);
    fetch_en = 0;
    check("R1 no fetch before frame_start", ncap == 0, ncap, 0);
  endtask

  task automatic t_sram();
    mem_sdram = 0; fetch_m1 = 2;
    start_a = 24'h0011F4; start_b = 24'h020000; start_c = 24'h030000;
    lines_a = 2; lines_b = 2; lines_c = 2;
    full_frame("R2 R3 R4 R6 sram order/stride/vertical-only", 0);
  endtask

  task automatic t_hpan();
    mem_sdram = 0; fetch_m1 = 3;
    start_a = 24'h000000; start_b = 24'h001000;
    start_c = 24'h040107;
    lines_a = 1; lines_b = 1; lines_c = 3;
    full_frame("R6 R7 third-area horizontal pan, odd start", 0);
  endtask

  task automatic t_sdram();
    mem_sdram = 1; sdram_row_bits = 4'd10; fetch_m1 = 1;
    start_a = 24'h1003FE; start_b = 24'h200000; start_c = 24'h300012;
    lines_a = 3; lines_b = 1; lines_c = 2;
    full_frame("R5 sdram stride 1024", 0);
    sdram_row_bits = 4'd8; fetch_m1 = 0;
    start_a = 24'h0000FF; lines_a = 4; lines_b = 0; lines_c = 1;
    full_frame("R5 sdram stride 256", 0);
  endtask

  task automatic t_skip();
    mem_sdram = 0; fetch_m1 = 1;
    start_a = 24'h000000; start_b = 24'h008000; start_c = 24'h00A000;
    lines_a = 2; lines_b = 0; lines_c = 2;
    full_frame("R9 empty middle area skipped", 0);
    lines_a = 0; lines_b = 0; lines_c = 0;
    full_frame("R9 all areas empty", 2);
  endtask

  task automatic t_shadow();
    int from;
    mem_sdram = 0; fetch_m1 = 1;
    start_a = 24'h002000; start_b = 24'h004000; start_c = 24'h006002;
    lines_a = 2; lines_b = 1; lines_c = 1;
    snap();
    pulse_frame();
    from = ncap;
    start_a = 24'h00A000; start_c = 24'h00C010; lines_b = 3; fetch_m1 = 5;
    mem_sdram = 1;
    drive_lines(4);
    verify("R8 mid-frame change ignored", from);
    full_frame("R8 change applied next frame", 0);
  endtask

  task automatic t_done_abort();
    int from;
    mem_sdram = 0; fetch_m1 = 2;
    start_a = 24'h001000; start_b = 24'h003000; start_c = 24'h005000;
    lines_a = 1; lines_b = 1; lines_c = 1;
    full_frame("R10 surplus line_start after frame end", 3);
    snap();
    pulse_frame();
    drive_lines(1);
    start_a = 24'h009000; lines_a = 2;
    snap();
    pulse_frame();
    from = ncap;
    drive_lines(4);
    verify("R10 frame_start restarts frame", from);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 0, 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sram();
    t_hpan();
    t_sdram();
    t_skip();
    t_shadow();
    t_done_abort();
    finish_run();
  end
endmodule